// File: doc/BRIEF.md
# Composite Sync Timing Decoder

This block watches a single, already-sliced composite sync bit from an interlaced video source and recovers three timing signals from it. The bit is active low: a sync tip is a low level, so every sync pulse opens on a falling edge and closes on a rising edge. The block samples the bit once per clock and measures line timing by counting clocks between edges. It produces three outputs: a burst-gate (back-porch) pulse after each sync pulse, a vertical sync pulse that marks the start of each vertical interval, and a flag that reports which of the two interlaced fields has just begun.

Vertical sync normally starts on the first rising edge that ends a broad (serrated) sync pulse. If a source sends one long low period with no serrations, vertical sync still starts after a fixed delay measured from the fall that opened that low period. Field parity comes from a one-bit flag. Each sync fall that arrives a full line after the previous fall clears the flag, and each fall that arrives at half-line spacing toggles it. The parity output loads this flag at the start of each vertical interval and holds it until the next one.

The sync input is a plain level with no valid/ready handshake, and the block has no back-pressure: every clock carries one sample. All three outputs are registered status pins. Default parameters give LINE_CLKS = 64, BP_WIDTH = 8, BROAD_MIN = 10, VS_DEFAULT = 40 and VS_WIDTH = 192. Every counter saturates at 4*LINE_CLKS - 1.

Top module: `csync_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, vsync_n = 1, bporch_n = 1 and field_odd = 0.
- R2: Every rising edge of csync_n drives bporch_n low two clocks later. If no further rising edge arrives, bporch_n then stays low for exactly BP_WIDTH clocks. bporch_n never falls without a preceding rising edge on csync_n.
- R3: A rising edge of csync_n that arrives while bporch_n is already low restarts the window. bporch_n then returns high BP_WIDTH clocks after the later edge's two-clock latency.
- R4: While the decoder is armed, a rising edge of csync_n that ends a low period longer than BROAD_MIN clocks drives vsync_n low two clocks later. This includes a low period of exactly BROAD_MIN+1 clocks.
- R5: While the decoder is armed, a single low period on csync_n that lasts more than VS_DEFAULT clocks drives vsync_n low VS_DEFAULT+2 clocks after the fall that opened it, even with no rising edge.
- R6: vsync_n stays low for exactly VS_WIDTH clocks. The decoder is disarmed during that time, so one vertical interval produces exactly one vsync_n pulse.
- R7: The parity flag reacts to each falling edge of csync_n. If the fall comes at least 3*LINE_CLKS/4 clocks after the previous fall (a full line), the flag is cleared. Otherwise (half line or equalizing pulse) the flag is inverted.
- R8: field_odd loads the parity flag in the same clock that vsync_n falls, and holds its value at all other times. With the default pattern, a field whose last picture line is full length reports 0, and a field that ends on a half line reports 1.
- R9: Sync low periods of BROAD_MIN clocks or less never start a vertical sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Sliced composite sync, low during a sync tip |
| vsync_n | output | 1 | Vertical sync, low for VS_WIDTH clocks from the start of a vertical interval |
| bporch_n | output | 1 | Burst-gate pulse, low for BP_WIDTH clocks after each sync rising edge |
| field_odd | output | 1 | Field parity captured at the last vertical sync start |

## Verification
The input passes through one sample register and one edge register, so bporch_n and a serration-triggered vsync_n respond in the clock two cycles after the clock in which the bench changed csync_n. The default-delay fall appears VS_DEFAULT+2 cycles after the fall that opened the long low period. The bench keeps a cycle count and records the cycle of every edge it drives. A monitor timestamps each output transition and measures each low-pulse length at the falling clock edge. Every check compares those timestamps and lengths with the driven edge cycle plus the latency stated in the requirement. Parity is read only after the whole vertical interval has passed, which makes its capture clock irrelevant to the result.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // one-cycle event flags produced by the edge timer
  typedef struct packed {
    logic fall;   // sync tip begins
    logic rise;   // sync tip ends
    logic low;    // currently inside a sync tip
  } sync_ev_t;

  // bits needed to hold the value n
  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/csd_edge_timer.sv
module csd_edge_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync_n,
  output csd_pkg::sync_ev_t ev,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] gap_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic smp_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b1;
      prv_q <= 1'b1;
    end else begin
      smp_q <= csync_n;
      prv_q <= smp_q;
    end
  end

  always_comb begin
    ev.fall = prv_q & ~smp_q;
    ev.rise = ~prv_q & smp_q;
    ev.low  = ~smp_q;
  end

  // length of the current / last sync tip in clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        low_len <= '0;
    else if (ev.fall)                  low_len <= CNT_W'(1);
    else if (ev.low && low_len != CNT_MAX) low_len <= low_len + 1'b1;
  end

  // clocks since the previous sync fall; starts saturated so the
  // first fall after reset counts as a full line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_len <= CNT_MAX;
    else if (ev.fall)           gap_len <= CNT_W'(1);
    else if (gap_len != CNT_MAX) gap_len <= gap_len + 1'b1;
  end

  // a rising edge always closes a tip that was measured
  assert_tip_measured_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rise |-> low_len != '0);

endmodule

// File: rtl/csd_porch_gen.sv
module csd_porch_gen #(
  parameter int BP_WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_p,
  output logic bporch_n
);
  localparam int BW = csd_pkg::bits_for(BP_WIDTH);
  localparam logic [BW-1:0] LOAD = BW'(BP_WIDTH - 1);

  logic [BW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bporch_n <= 1'b1;
      left_q   <= '0;
    end else if (rise_p) begin
      bporch_n <= 1'b0;
      left_q   <= LOAD;
    end else if (!bporch_n) begin
      if (left_q == '0) bporch_n <= 1'b1;
      else              left_q   <= left_q - 1'b1;
    end
  end

  assert_bp_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> !bporch_n);

  assert_bp_only_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bporch_n && !rise_p) |=> bporch_n);

endmodule

// File: rtl/csd_vsync_gen.sv
module csd_vsync_gen #(
  parameter int CNT_W      = 8,
  parameter int BROAD_MIN  = 10,
  parameter int VS_DEFAULT = 40,
  parameter int VS_WIDTH   = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_p,
  input  logic             rise_p,
  input  logic             low_p,
  input  logic [CNT_W-1:0] low_len,
  output logic             vsync_n,
  output logic             vs_start
);
  localparam int VW = csd_pkg::bits_for(VS_WIDTH);
  localparam logic [CNT_W-1:0] BROAD_L = CNT_W'(BROAD_MIN);
  localparam logic [CNT_W-1:0] DFLT_L  = CNT_W'(VS_DEFAULT);
  localparam logic [VW-1:0]    LOAD    = VW'(VS_WIDTH - 1);

  logic [VW-1:0] left_q;
  logic broad_rise, dflt_hit, armed;

  always_comb begin
    armed      = vsync_n;
    broad_rise = rise_p && (low_len > BROAD_L);
    dflt_hit   = low_p && !fall_p && (low_len == DFLT_L);
    vs_start   = armed && (broad_rise || dflt_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsync_n <= 1'b1;
      left_q  <= '0;
    end else if (vs_start) begin
      vsync_n <= 1'b0;
      left_q  <= LOAD;
    end else if (!vsync_n) begin
      if (left_q == '0) vsync_n <= 1'b1;
      else              left_q  <= left_q - 1'b1;
    end
  end

  // checker: length of the current vsync low run
  logic [VW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (vsync_n)      run_q <= '0;
    else if (run_q != '1)  run_q <= run_q + 1'b1;
  end

  assert_vs_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> run_q < VW'(VS_WIDTH));

  assert_vs_full_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> run_q == VW'(VS_WIDTH));

  assert_vs_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(rise_p || low_p));

endmodule

// File: rtl/csd_field_det.sv
module csd_field_det #(
  parameter int CNT_W    = 8,
  parameter int FULL_MIN = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_p,
  input  logic [CNT_W-1:0] gap_len,
  input  logic             vs_start,
  output logic             field_odd
);
  localparam logic [CNT_W-1:0] FULL_L = CNT_W'(FULL_MIN);

  logic tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (fall_p)  tgl_q <= (gap_len >= FULL_L) ? 1'b0 : ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         field_odd <= 1'b0;
    else if (vs_start)  field_odd <= tgl_q;
  end

  assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_start |=> $stable(field_odd));

endmodule

// File: rtl/csync_decoder.sv
module csync_decoder #(
  parameter int LINE_CLKS  = 64,
  parameter int BP_WIDTH   = 8,
  parameter int BROAD_MIN  = 10,
  parameter int VS_DEFAULT = 40,
  parameter int VS_WIDTH   = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n,
  output logic bporch_n,
  output logic field_odd
);
  localparam int CNT_W    = csd_pkg::bits_for(LINE_CLKS * 4 - 1);
  localparam int FULL_MIN = (LINE_CLKS * 3) / 4;

  csd_pkg::sync_ev_t ev;
  logic [CNT_W-1:0] low_len, gap_len;
  logic vs_start;

  csd_edge_timer #(.CNT_W(CNT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
    .ev(ev), .low_len(low_len), .gap_len(gap_len)
  );

  csd_porch_gen #(.BP_WIDTH(BP_WIDTH)) u_porch (
    .clk(clk), .rst_n(rst_n), .rise_p(ev.rise), .bporch_n(bporch_n)
  );

  csd_vsync_gen #(
    .CNT_W(CNT_W), .BROAD_MIN(BROAD_MIN),
    .VS_DEFAULT(VS_DEFAULT), .VS_WIDTH(VS_WIDTH)
  ) u_vsync (
    .clk(clk), .rst_n(rst_n),
    .fall_p(ev.fall), .rise_p(ev.rise), .low_p(ev.low),
    .low_len(low_len), .vsync_n(vsync_n), .vs_start(vs_start)
  );

  csd_field_det #(.CNT_W(CNT_W), .FULL_MIN(FULL_MIN)) u_field (
    .clk(clk), .rst_n(rst_n), .fall_p(ev.fall), .gap_len(gap_len),
    .vs_start(vs_start), .field_odd(field_odd)
  );

endmodule

// File: tb/csync_decoder_test.sv
module csync_decoder_test;
  localparam int LINE  = 64;
  localparam int HALF  = LINE / 2;
  localparam int BP_W  = 8;
  localparam int BMIN  = 10;
  localparam int DFLT  = 40;
  localparam int VS_W  = 192;
  localparam int HS    = 5;
  localparam int EQ    = 2;
  localparam int BROAD = 27;
  localparam int LONG  = 160;

  // {half line before vertical, serrated vertical, expected field_odd}
  localparam logic [2:0] SCEN [4] = '{3'b010, 3'b111, 3'b000, 3'b101};

  logic clk = 1'b0, rst_n = 1'b0, csync_n = 1'b1;
  logic vsync_n, bporch_n, field_odd;

  csync_decoder #(.LINE_CLKS(LINE), .BP_WIDTH(BP_W), .BROAD_MIN(BMIN),
    .VS_DEFAULT(DFLT), .VS_WIDTH(VS_W)) uut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
    .vsync_n(vsync_n), .bporch_n(bporch_n), .field_odd(field_odd));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int fall_c = 0, rise_c = 0;
  int vs_fall_cyc = -1, vs_count = 0, vs_run = 0, vs_w = 0;
  int bp_fall_cyc = -1, bp_run = 0, bp_w = 0;
  logic vs_prev = 1'b1, bp_prev = 1'b1;

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (vs_prev && !vsync_n) begin vs_fall_cyc = cyc; vs_count++; vs_run = 0; end
      if (!vsync_n) vs_run++;
      if (!vs_prev && vsync_n) vs_w = vs_run;
      if (bp_prev && !bporch_n) begin bp_fall_cyc = cyc; bp_run = 0; end
      if (!bporch_n) bp_run++;
      if (!bp_prev && bporch_n) bp_w = bp_run;
    end
    vs_prev = vsync_n;
    bp_prev = bporch_n;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int low, input int period);
    csync_n = 1'b0;
    fall_c = cyc;
    repeat (low) @(negedge clk);
    csync_n = 1'b1;
    rise_c = cyc;
    repeat (period - low) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n0, r1, exp_vs;
    logic prev_f;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 vsync_n in reset", vsync_n, 1);
    chk("R1 bporch_n in reset", bporch_n, 1);
    chk("R1 field_odd in reset", field_odd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 vsync_n after release", vsync_n, 1);
    chk("R1 bporch_n after release", bporch_n, 1);
    prev_f = 1'b0;

    for (int i = 0; i < 4; i++) begin
      repeat (4) pulse(HS, LINE);
      #1;
      chk("R2 bporch fall cycle", bp_fall_cyc, rise_c + 2);
      chk("R2 bporch width", bp_w, BP_W);
      chk("R8 field held between verticals", field_odd, prev_f);
      n0 = vs_count;
      if (SCEN[i][2]) pulse(HS, HALF);
      repeat (6) pulse(EQ, HALF);
      if (SCEN[i][1]) begin
        pulse(BROAD, HALF);
        exp_vs = rise_c + 2;
        repeat (5) pulse(BROAD, HALF);
      end else begin
        pulse(LONG, LONG + HALF);
        exp_vs = fall_c + DFLT + 2;
      end
      repeat (6) pulse(EQ, HALF);
      repeat (4) pulse(HS, LINE);
      #1;
      if (SCEN[i][1]) chk("R4 vsync start on serration", vs_fall_cyc, exp_vs);
      else            chk("R5 vsync default delay", vs_fall_cyc, exp_vs);
      chk("R6 vsync width", vs_w, VS_W);
      chk("R6 one vsync per interval", vs_count - n0, 1);
      chk("R7 field parity", field_odd, SCEN[i][0]);
      prev_f = SCEN[i][0];
    end

    // R9: tips of exactly BROAD_MIN clocks are not broad
    n0 = vs_count;
    repeat (3) pulse(BMIN, LINE);
    #1;
    chk("R9 no vsync at BROAD_MIN", vs_count - n0, 0);
    chk("R8 field unchanged without vsync", field_odd, prev_f);

    // R4 boundary: BROAD_MIN+1 is broad
    pulse(BMIN + 1, LINE);
    exp_vs = rise_c + 2;
    repeat (4) pulse(HS, LINE);
    #1;
    chk("R4 vsync at BROAD_MIN+1", vs_fall_cyc, exp_vs);
    chk("R6 single vsync at boundary", vs_count - n0, 1);

    // R3: second edge inside the porch window restarts it
    pulse(EQ, 5);
    r1 = rise_c;
    pulse(EQ, LINE);
    #1;
    chk("R3 bporch fall cycle", bp_fall_cyc, r1 + 2);
    chk("R3 bporch restarted width", bp_w, (rise_c - r1) + BP_W);

    // R1: reset while vsync is active
    pulse(BMIN + 1, 20);
    #1;
    chk("R4 vsync active before reset", vsync_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 vsync_n forced high", vsync_n, 1);
    chk("R1 field_odd forced low", field_odd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule